// File: doc/BRIEF.md
# Halo Tile Block Loader

This block fills a two-dimensional array of pixel processors with one image tile at a time, together with a border of neighbouring pixels that local filters need. Pixels arrive serially, one per accepted cycle. A short horizontal staging register assembles each tile row; once a row is complete it is pushed into the top of a set of vertical register chains, and every chain moves down by one row. The chains are cut into per-processor blocks whose size depends on where the processor sits: corner processors hold a square of halo, border processors a strip, interior processors a single pixel.

The producer sends the tile in reverse raster order, bottom-right pixel first, so that after the final row push every pixel already sits in the register owned by its processor. When the whole tile, core plus halo, has arrived, the loader raises a full flag and takes no more pixels. A single-cycle copy command then moves every chain register into the processors' held outputs at once. The loader is free for the next tile from the following cycle while the processors work on the copied data.

Top module: `halo_tile_loader`

## Requirements
- R1: After synchronous reset, tile_full is low and every bit of proc_regs is zero.
- R2: With tile width TW = NW+2R and height TH = NH+2R, tile_full rises in the cycle after the TW*TH-th accepted pixel and not earlier; cycles with pix_valid low are not counted.
- R3: When a tile is fed in reverse raster order (the pixel at row k/TW, column k%TW sent for k from TW*TH-1 down to 0), after the copy each processor slot holds the tile pixel of its owned position.
- R4: Processor (row i, column j) owns tile columns 0..R when j=0, NW-1+R..NW-1+2R when j=NW-1, and j+R otherwise; its tile rows follow the same rule with i and NH. Within a processor, slot s = local_row*owned_width + local_col, top-left first; slots past owned_width*owned_height read zero. proc_regs packs slot s of processor (i,j) at bits ((i*NW+j)*(R+1)^2+s)*PW upward.
- R5: While tile_full is high, pix_valid is ignored: extra pixels neither change the tile that is later copied nor clear tile_full.
- R6: copy_go while tile_full is low is ignored: proc_regs keep their value and the pixel count continues.
- R7: copy_go while tile_full is high updates proc_regs at that edge, drops tile_full the next cycle, and a pixel presented in that next cycle is accepted as the first pixel of the next tile.
- R8: proc_regs hold their value between copies, including while the next tile is loading.
- R9: With R = 0 every processor owns one slot holding tile pixel (i, j).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | A pixel is present on pix_data |
| pix_data | input | PW | Serial pixel value |
| copy_go | input | 1 | Global copy command |
| tile_full | output | 1 | Whole tile plus halo has been received |
| proc_regs | output | NH*NW*(R+1)^2*PW | Per-processor held pixel slots |

## Verification
The bench numbers each pixel by its tile coordinates and checks every slot of every processor, so a wrong ownership base, a swapped column order in the row staging or a missing halo strip shows up as a wrong coordinate in a specific corner or border processor. A stray copy issued mid-load must not restart the count, otherwise the full flag arrives late. Pixels pushed while full would shift rows and corrupt the copied tile, and a copy that swallowed the first pixel of the next tile would shift the following tile by one place. A second instance with no halo checks that the degenerate sizing still gives one register per processor.

// File: rtl/halo_pkg.sv
package halo_pkg;

    // Number of tile positions owned along one axis by the node at index k
    function automatic int span_of(input int k, input int n, input int r);
        if (k == 0 || k == n - 1) return r + 1;
        return 1;
    endfunction

    // First tile position owned along one axis by the node at index k
    function automatic int base_of(input int k, input int n, input int r);
        if (k == 0) return 0;
        if (k == n - 1) return n - 1 + r;
        return k + r;
    endfunction

    function automatic int slot_count(input int r);
        return (r + 1) * (r + 1);
    endfunction

endpackage

// File: rtl/halo_feed.sv
module halo_feed #(
    parameter int PW    = 8,
    parameter int TW    = 8,
    parameter int TOTAL = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pix_valid,
    input  logic [PW-1:0]          pix_data,
    input  logic                   copy_go,
    output logic                   push,
    output logic [TW-1:0][PW-1:0]  push_row,
    output logic                   tile_full,
    output logic                   copy_en
);
    localparam int CW   = $clog2(TOTAL + 1);
    localparam int COLW = $clog2(TW);

    logic [CW-1:0]           cnt_q;
    logic [COLW-1:0]         col_q;
    logic [TW-2:0][PW-1:0]   stage_q;
    logic                    accept;

    assign tile_full = (cnt_q == CW'(TOTAL));
    assign accept    = pix_valid && !tile_full;
    assign push      = accept && (col_q == COLW'(TW - 1));
    assign copy_en   = copy_go && tile_full;

    // newest pixel is leftmost; oldest of the row (fed first) is rightmost
    always_comb begin
        push_row[0] = pix_data;
        for (int c = 1; c < TW; c++) push_row[c] = stage_q[c-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            col_q   <= '0;
            stage_q <= '0;
        end else begin
            if (copy_en) begin
                cnt_q <= '0;
                col_q <= '0;
            end else if (accept) begin
                cnt_q <= cnt_q + 1'b1;
                col_q <= push ? '0 : col_q + 1'b1;
            end
            if (accept) begin
                stage_q[0] <= pix_data;
                for (int i = 1; i < TW - 1; i++) stage_q[i] <= stage_q[i-1];
            end
        end
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(TOTAL));

    p_full_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        tile_full && !copy_go |=> tile_full);

    p_no_push_when_full_r5: assert property (@(posedge clk) disable iff (rst)
        tile_full |-> !push);

    p_copy_clears_r7: assert property (@(posedge clk) disable iff (rst)
        copy_en |=> !tile_full);

endmodule

// File: rtl/halo_node.sv
module halo_node #(
    parameter int PW    = 8,
    parameter int OW    = 1,
    parameter int OH    = 1,
    parameter int SLOTS = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      shift_en,
    input  logic                      copy_en,
    input  logic [OW-1:0][PW-1:0]     col_in,
    output logic [OW-1:0][PW-1:0]     col_out,
    output logic [SLOTS-1:0][PW-1:0]  held
);
    logic [OH-1:0][OW-1:0][PW-1:0] chain_q;
    logic [SLOTS-1:0][PW-1:0]      held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else if (shift_en) begin
            chain_q[0] <= col_in;
            for (int k = 1; k < OH; k++) chain_q[k] <= chain_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (copy_en) begin
            for (int s = 0; s < OW * OH; s++) held_q[s] <= chain_q[s / OW][s % OW];
        end
    end

    assign col_out = chain_q[OH-1];
    assign held    = held_q;

    p_chain_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(chain_q));

    p_held_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        !copy_en |=> $stable(held_q));

endmodule

// File: rtl/halo_tile_loader.sv
module halo_tile_loader #(
    parameter int NW = 4,
    parameter int NH = 4,
    parameter int R  = 2,
    parameter int PW = 8
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        pix_valid,
    input  logic [PW-1:0]                               pix_data,
    input  logic                                        copy_go,
    output logic                                        tile_full,
    output logic [NH*NW*halo_pkg::slot_count(R)*PW-1:0] proc_regs
);
    localparam int TW    = NW + 2 * R;
    localparam int TH    = NH + 2 * R;
    localparam int TOTAL = TW * TH;
    localparam int SLOTS = halo_pkg::slot_count(R);

    logic                  push;
    logic                  copy_en;
    logic [TW-1:0][PW-1:0] vrow [NH+1];

    halo_feed #(.PW(PW), .TW(TW), .TOTAL(TOTAL)) u_feed (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .copy_go   (copy_go),
        .push      (push),
        .push_row  (vrow[0]),
        .tile_full (tile_full),
        .copy_en   (copy_en)
    );

    for (genvar i = 0; i < NH; i++) begin : g_row
        for (genvar j = 0; j < NW; j++) begin : g_col
            localparam int OW = halo_pkg::span_of(j, NW, R);
            localparam int OH = halo_pkg::span_of(i, NH, R);
            localparam int BC = halo_pkg::base_of(j, NW, R);

            logic [SLOTS-1:0][PW-1:0] n_held;

            halo_node #(.PW(PW), .OW(OW), .OH(OH), .SLOTS(SLOTS)) u_node (
                .clk      (clk),
                .rst      (rst),
                .shift_en (push),
                .copy_en  (copy_en),
                .col_in   (vrow[i][BC +: OW]),
                .col_out  (vrow[i+1][BC +: OW]),
                .held     (n_held)
            );

            assign proc_regs[(i*NW+j)*SLOTS*PW +: SLOTS*PW] = n_held;
        end
    end

    p_bottom_still_r3: assert property (@(posedge clk) disable iff (rst)
        !push |=> $stable(vrow[NH]));

    p_regs_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(copy_go && tile_full) |=> $stable(proc_regs));

endmodule

// File: tb/halo_tile_loader_bench.sv
`timescale 1ns/1ps
module halo_tile_loader_bench;
    localparam int NW = 4, NH = 4, R = 2, PW = 8;
    localparam int TW = NW + 2*R, TH = NH + 2*R, TOT = TW*TH, SL = (R+1)*(R+1);
    localparam int BNW = 3, BNH = 2, BTOT = BNW*BNH;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic                      a_valid = 1'b0, a_copy = 1'b0, a_full;
    logic [PW-1:0]             a_data = '0;
    logic [NH*NW*SL*PW-1:0]    a_regs;
    logic                      b_valid = 1'b0, b_copy = 1'b0, b_full;
    logic [PW-1:0]             b_data = '0;
    logic [BNH*BNW*PW-1:0]     b_regs;

    halo_tile_loader #(.NW(NW), .NH(NH), .R(R), .PW(PW)) u_halo_tile_loader (
        .clk(clk), .rst(rst), .pix_valid(a_valid), .pix_data(a_data),
        .copy_go(a_copy), .tile_full(a_full), .proc_regs(a_regs));

    halo_tile_loader #(.NW(BNW), .NH(BNH), .R(0), .PW(PW)) u_halo_tile_loader_r0 (
        .clk(clk), .rst(rst), .pix_valid(b_valid), .pix_data(b_data),
        .copy_go(b_copy), .tile_full(b_full), .proc_regs(b_regs));

    int checks = 0, fails = 0;
    bit done = 1'b0;

    function automatic logic [PW-1:0] pixv(int row, int col, int tw, int seed);
        return PW'((row*tw + col + seed) & 255);
    endfunction

    function automatic int span(int k, int n, int r);
        return (k == 0 || k == n-1) ? r+1 : 1;
    endfunction

    function automatic int base(int k, int n, int r);
        if (k == 0) return 0;
        if (k == n-1) return n-1+r;
        return k+r;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_a_tile(int seed, string req);
        for (int i = 0; i < NH; i++)
            for (int j = 0; j < NW; j++) begin
                int ow = span(j, NW, R), oh = span(i, NH, R);
                for (int s = 0; s < SL; s++) begin
                    logic [PW-1:0] exp, act;
                    act = a_regs[((i*NW+j)*SL+s)*PW +: PW];
                    if (s < ow*oh)
                        exp = pixv(base(i, NH, R) + s/ow, base(j, NW, R) + s%ow, TW, seed);
                    else
                        exp = '0;
                    check(act == exp, req, $sformatf("proc(%0d,%0d) slot %0d", i, j, s), act, exp);
                end
            end
    endtask

    // called at a negedge; returns at a negedge with pix_valid low
    task automatic feed_a(int seed, int hi, int lo, bit gaps);
        for (int k = hi; k >= lo; k--) begin
            if (gaps && (k % 7 == 3)) begin
                a_valid = 1'b0;
                @(negedge clk);
            end
            a_valid = 1'b1;
            a_data  = pixv(k / TW, k % TW, TW, seed);
            @(negedge clk);
        end
        a_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(a_full == 1'b0, "R1", "tile_full after reset", a_full, 0);
        check(a_regs == '0, "R1", "proc_regs after reset", a_regs[63:0], 0);
        check(b_regs == '0, "R1", "r0 proc_regs after reset", b_regs, 0);

        // first tile, with idle gaps and a stray copy mid-load
        feed_a(0, TOT-1, 40, 1'b1);
        a_copy = 1'b1;
        @(negedge clk);
        a_copy = 1'b0;
        check(a_regs == '0, "R6", "proc_regs after stray copy", a_regs[63:0], 0);
        check(a_full == 1'b0, "R6", "tile_full after stray copy", a_full, 0);
        feed_a(0, 39, 1, 1'b1);
        check(a_full == 1'b0, "R2", "tile_full one pixel early", a_full, 0);
        feed_a(0, 0, 0, 1'b0);
        check(a_full == 1'b1, "R2", "tile_full after last pixel", a_full, 1);

        // R5: junk while full
        for (int n = 0; n < 10; n++) begin
            a_valid = 1'b1;
            a_data  = 8'hEE;
            @(negedge clk);
        end
        a_valid = 1'b0;
        check(a_full == 1'b1, "R5", "tile_full held under extra input", a_full, 1);
        check(a_regs == '0, "R8", "proc_regs before any copy", a_regs[63:0], 0);

        // copy, then next tile back to back
        a_copy = 1'b1;
        @(negedge clk);
        a_copy = 1'b0;
        check(a_full == 1'b0, "R7", "tile_full after copy", a_full, 0);
        check_a_tile(0, "R3");
        feed_a(100, TOT-1, 30, 1'b0);
        check_a_tile(0, "R8");
        feed_a(100, 29, 1, 1'b0);
        check(a_full == 1'b0, "R7", "second tile full early", a_full, 0);
        feed_a(100, 0, 0, 1'b0);
        check(a_full == 1'b1, "R7", "second tile full on time", a_full, 1);
        a_copy = 1'b1;
        @(negedge clk);
        a_copy = 1'b0;
        check_a_tile(100, "R4");

        // R9: no halo instance
        for (int k = BTOT-1; k >= 0; k--) begin
            b_valid = 1'b1;
            b_data  = pixv(k / BNW, k % BNW, BNW, 40);
            @(negedge clk);
        end
        b_valid = 1'b0;
        check(b_full == 1'b1, "R9", "r0 tile_full", b_full, 1);
        b_copy = 1'b1;
        @(negedge clk);
        b_copy = 1'b0;
        for (int i = 0; i < BNH; i++)
            for (int j = 0; j < BNW; j++) begin
                logic [PW-1:0] act;
                act = b_regs[(i*BNW+j)*PW +: PW];
                check(act == pixv(i, j, BNW, 40), "R9",
                      $sformatf("r0 proc(%0d,%0d)", i, j), act, pixv(i, j, BNW, 40));
            end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule